// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block is the transmit side of a network controller's DMA engine. Software builds a circular linked list of 16-byte descriptors in memory for each of two transmit queues. It then pulses a start bit for one queue or both. The engine latches each requested queue's head pointer and visits descriptors from the head onward. It stops after the descriptor whose next pointer leads back to the head.

For every descriptor that hardware owns, the engine fetches the frame buffer a word at a time and streams the bytes out on a ready/valid byte port, with a marker on the last byte. It then writes the command word back with the ownership bit cleared and pulses the queue's done cause bit. Descriptors that hardware does not own are stepped over. Oversized frames are dropped, but their descriptors are still released.

Memory traffic uses a single word-wide request port with a grant, and read data returns on a separate valid strobe. A one-cycle done pulse marks the end of each command, so the surrounding interrupt logic can evaluate its mask once per command.

Top module: `txring_walker`

## Requirements
- R1: After reset the engine is idle: busy, done, memory request, packet valid and every cause bit are low. While idle it issues no memory request and no packet byte.
- R2: A descriptor at byte address A occupies words A, A+4, A+8 and A+12:
  - command/status, with the ownership flag in bit 31;
  - bits 31:16 hold the byte count, and bits 15:0 are ignored;
  - the buffer byte address;
  - the next descriptor address.
- R3: A start pulse latches the head pointer of each requested queue. The walk begins at that head and ends after the descriptor whose next pointer equals the head.
- R4: A descriptor whose ownership flag is clear produces no packet bytes, no write-back and no cause pulse, and the walk follows its next pointer.
- R5: An owned descriptor with a count from 1 to 2047 streams exactly that many bytes. They come from the buffer byte address upward, in little-endian lane order, at any alignment, and the last flag marks the final byte.
- R6: An owned descriptor with a count of 2048 or more, or of zero, streams no bytes.
- R7: Every owned descriptor gets a write of its command word, with bit 31 cleared and the other bits unchanged, to its own address. A one-cycle pulse then follows on cause bit 3 for queue 0 or cause bit 2 for queue 1.
- R8: When both start bits arrive in one cycle, queue 1 is walked completely before queue 0. A single done pulse, with busy already low, follows the last walk.
- R9: Start pulses that arrive while busy is high are ignored.
- R10: While packet valid is high and ready is low, the byte and the last flag hold steady.
- R11: A memory request that is not granted stays asserted, with the same address and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | NQ | Start pulse per queue; bit 1 is queue 1 |
| head_i | input | NQ*AW | Head pointers, queue q at bits q*AW upward |
| busy_o | output | 1 | A command is being processed |
| done_o | output | 1 | One-cycle pulse when the command's walks are finished |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| pkt_data_o | output | 8 | Frame byte |
| pkt_valid_o | output | 1 | Frame byte valid |
| pkt_last_o | output | 1 | Final byte of the frame |
| pkt_ready_i | input | 1 | Sink accepts the byte |
| cause_set_o | output | CAUSE_W | One-cycle cause set pulses |

## Verification
Two events can coincide in one cycle: the start bits of both queues, and a start request arriving while a walk is still in progress. The bench raises both start bits in the same cycle and judges the order from two logs: the cause pulses (bit 2 before bit 3) and the streamed frames (queue 1's bytes first). It also checks that exactly one done pulse follows. In a second case it pulses queue 0's start while queue 1 is busy. It then confirms that queue 0's descriptor stays owned, that no frame or cause appears for it, and that the engine returns to idle.

// File: rtl/txw_pkg.sv
package txw_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LOAD,
    ST_DREQ,
    ST_DWAIT,
    ST_BREQ,
    ST_BWAIT,
    ST_BOUT,
    ST_WB,
    ST_NEXT,
    ST_QEND
  } walk_st_t;

  localparam int OWN_BIT    = 31;
  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 4;
  localparam int CNT_W      = 16;
endpackage

// File: rtl/txw_rst_sync.sv
module txw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/txw_qsel.sv
// Latches the requested queues and their head pointers; the highest pending
// queue index is served first.
module txw_qsel #(
  parameter int NQ = 2,
  parameter int AW = 32,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic [NQ-1:0]   start_i,
  input  logic [NQ*AW-1:0] head_i,
  input  logic            qdone,
  output logic            any_pend,
  output logic [QW-1:0]   cur_q,
  output logic [AW-1:0]   cur_head
);
  logic [NQ-1:0] pend_q, pend_n;
  logic [AW-1:0] head_q [NQ];

  always_comb begin
    cur_q = '0;
    for (int i = 0; i < NQ; i++) begin
      if (pend_q[i]) cur_q = QW'(i);
    end
  end

  always_comb begin
    pend_n = pend_q;
    if (accept)     pend_n = start_i;
    else if (qdone) pend_n = pend_q & ~(NQ'(1) << cur_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_n;
  end

  for (genvar g = 0; g < NQ; g++) begin : g_head
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      head_q[g] <= '0;
      else if (accept) head_q[g] <= head_i[g*AW +: AW];
    end
  end

  assign any_pend = |pend_q;
  assign cur_head = head_q[cur_q];
endmodule

// File: rtl/txw_pump.sv
// Holds one fetched buffer word and hands out its bytes lane by lane.
module txw_pump #(
  parameter int AW    = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [AW-1:0]    base,
  input  logic [CNT_W-1:0] count,
  input  logic             word_we,
  input  logic [31:0]      word_in,
  input  logic             fire,
  output logic [7:0]       byte_o,
  output logic             last_o,
  output logic             lane_end,
  output logic [AW-1:0]    fetch_addr
);
  logic [AW-1:0]    addr_q, addr_n;
  logic [CNT_W-1:0] rem_q, rem_n;
  logic [31:0]      word_q;

  always_comb begin
    addr_n = addr_q;
    rem_n  = rem_q;
    if (load) begin
      addr_n = base;
      rem_n  = count;
    end else if (fire) begin
      addr_n = addr_q + AW'(1);
      rem_n  = rem_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else begin
      addr_q <= addr_n;
      rem_q  <= rem_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_we) word_q <= word_in;
  end

  assign byte_o     = word_q[{addr_q[1:0], 3'b000} +: 8];
  assign last_o     = (rem_q == CNT_W'(1));
  assign lane_end   = (addr_q[1:0] == 2'b11);
  assign fetch_addr = {addr_q[AW-1:2], 2'b00};
endmodule

// File: rtl/txring_walker.sv
module txring_walker
  import txw_pkg::*;
#(
  parameter int AW        = 32,
  parameter int NQ        = 2,
  parameter int LEN_LIMIT = 2048,
  parameter int CAUSE_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NQ-1:0]      start_i,
  input  logic [NQ*AW-1:0]   head_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic [31:0]        mem_wdata_o,
  input  logic               mem_gnt_i,
  input  logic               mem_rvalid_i,
  input  logic [31:0]        mem_rdata_i,
  output logic [7:0]         pkt_data_o,
  output logic               pkt_valid_o,
  output logic               pkt_last_o,
  input  logic               pkt_ready_i,
  output logic [CAUSE_W-1:0] cause_set_o
);
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1;

  logic srst_n;
  walk_st_t st_q, st_n;
  logic [1:0]       widx_q, widx_n;
  logic [AW-1:0]    ptr_q, ptr_n;
  logic [31:0]      cmd_w;
  logic [CNT_W-1:0] cnt_w;
  logic [AW-1:0]    buf_w, nxt_w;
  logic [CAUSE_W-1:0] cause_q, cause_n;
  logic             done_q, done_n;

  logic accept, qdone, any_pend;
  logic [QW-1:0] cur_q;
  logic [AW-1:0] cur_head;
  logic pump_load, pump_we, pump_fire, pump_last, lane_end;
  logic [7:0] pump_byte;
  logic [AW-1:0] fetch_addr;
  logic dword_en, owned, oversize;

  txw_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_o(srst_n));

  txw_qsel #(.NQ(NQ), .AW(AW)) u_qsel (
    .clk(clk), .rst_n(srst_n), .accept(accept), .start_i(start_i),
    .head_i(head_i), .qdone(qdone), .any_pend(any_pend),
    .cur_q(cur_q), .cur_head(cur_head)
  );

  txw_pump #(.AW(AW), .CNT_W(CNT_W)) u_pump (
    .clk(clk), .rst_n(srst_n), .load(pump_load), .base(buf_w), .count(cnt_w),
    .word_we(pump_we), .word_in(mem_rdata_i), .fire(pump_fire),
    .byte_o(pump_byte), .last_o(pump_last), .lane_end(lane_end),
    .fetch_addr(fetch_addr)
  );

  assign accept    = (st_q == ST_IDLE) && (|start_i);
  assign qdone     = (st_q == ST_NEXT) && (nxt_w == cur_head);
  assign dword_en  = (st_q == ST_DWAIT) && mem_rvalid_i;
  assign owned     = cmd_w[OWN_BIT];
  assign oversize  = (32'(cnt_w) >= LEN_LIMIT) || (cnt_w == '0);
  assign pump_load = dword_en && (widx_q == 2'd3) && owned && !oversize;
  assign pump_we   = (st_q == ST_BWAIT) && mem_rvalid_i;
  assign pump_fire = (st_q == ST_BOUT) && pkt_ready_i;

  // next-state logic
  always_comb begin
    st_n    = st_q;
    widx_n  = widx_q;
    ptr_n   = ptr_q;
    cause_n = '0;
    done_n  = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (accept) st_n = ST_LOAD;
      ST_LOAD: begin
        ptr_n  = cur_head;
        widx_n = 2'd0;
        st_n   = ST_DREQ;
      end
      ST_DREQ:  if (mem_gnt_i) st_n = ST_DWAIT;
      ST_DWAIT: begin
        if (mem_rvalid_i) begin
          if (widx_q != 2'd3) begin
            widx_n = widx_q + 2'd1;
            st_n   = ST_DREQ;
          end else if (!owned) begin
            st_n = ST_NEXT;
          end else if (oversize) begin
            st_n = ST_WB;
          end else begin
            st_n = ST_BREQ;
          end
        end
      end
      ST_BREQ:  if (mem_gnt_i) st_n = ST_BWAIT;
      ST_BWAIT: if (mem_rvalid_i) st_n = ST_BOUT;
      ST_BOUT: begin
        if (pkt_ready_i) begin
          if (pump_last)     st_n = ST_WB;
          else if (lane_end) st_n = ST_BREQ;
        end
      end
      ST_WB: begin
        if (mem_gnt_i) begin
          cause_n = CAUSE_W'(1) << (CAUSE_W - 1 - int'(cur_q));
          st_n    = ST_NEXT;
        end
      end
      ST_NEXT: begin
        if (qdone) begin
          st_n = ST_QEND;
        end else begin
          ptr_n  = nxt_w;
          widx_n = 2'd0;
          st_n   = ST_DREQ;
        end
      end
      ST_QEND: begin
        if (any_pend) begin
          st_n = ST_LOAD;
        end else begin
          done_n = 1'b1;
          st_n   = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q    <= ST_IDLE;
      widx_q  <= '0;
      ptr_q   <= '0;
      cause_q <= '0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      widx_q  <= widx_n;
      ptr_q   <= ptr_n;
      cause_q <= cause_n;
      done_q  <= done_n;
    end
  end

  // descriptor word capture, one enable per word
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cmd_w <= '0;
      cnt_w <= '0;
      buf_w <= '0;
      nxt_w <= '0;
    end else if (dword_en) begin
      case (widx_q)
        2'd0:    cmd_w <= mem_rdata_i;
        2'd1:    cnt_w <= mem_rdata_i[31:16];
        2'd2:    buf_w <= AW'(mem_rdata_i);
        default: nxt_w <= AW'(mem_rdata_i);
      endcase
    end
  end

  always_comb begin
    mem_addr_o = ptr_q;
    if (st_q == ST_DREQ)      mem_addr_o = ptr_q + AW'({widx_q, 2'b00});
    else if (st_q == ST_BREQ) mem_addr_o = fetch_addr;
  end

  assign mem_req_o   = (st_q == ST_DREQ) || (st_q == ST_BREQ) || (st_q == ST_WB);
  assign mem_we_o    = (st_q == ST_WB);
  assign mem_wdata_o = cmd_w & ~(32'd1 << OWN_BIT);
  assign pkt_valid_o = (st_q == ST_BOUT);
  assign pkt_data_o  = pump_byte;
  assign pkt_last_o  = (st_q == ST_BOUT) && pump_last;
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign cause_set_o = cause_q;
endmodule

// File: rtl/txw_chk.sv
module txw_chk #(
  parameter int AW      = 32,
  parameter int CAUSE_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy_o,
  input logic               done_o,
  input logic               mem_req_o,
  input logic               mem_we_o,
  input logic [AW-1:0]      mem_addr_o,
  input logic [31:0]        mem_wdata_o,
  input logic               mem_gnt_i,
  input logic [7:0]         pkt_data_o,
  input logic               pkt_valid_o,
  input logic               pkt_last_o,
  input logic               pkt_ready_i,
  input logic [CAUSE_W-1:0] cause_set_o
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_req_o && !pkt_valid_o));

  assert_wb_own_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> !mem_wdata_o[31]);

  assert_cause_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cause_set_o) && (cause_set_o[1:0] == 2'b00));

  assert_cause_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_set_o != '0) |=> (cause_set_o == '0));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_pkt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid_o && !pkt_ready_i) |=>
      (pkt_valid_o && $stable(pkt_data_o) && $stable(pkt_last_o)));

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_gnt_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
endmodule

bind txring_walker txw_chk #(.AW(AW), .CAUSE_W(CAUSE_W)) u_txw_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o), .mem_gnt_i(mem_gnt_i),
  .pkt_data_o(pkt_data_o), .pkt_valid_o(pkt_valid_o),
  .pkt_last_o(pkt_last_o), .pkt_ready_i(pkt_ready_i),
  .cause_set_o(cause_set_o)
);

// File: tb/test_txring_walker.sv
`timescale 1ns/1ps
module test_txring_walker;
  localparam int AW = 32;
  localparam logic [31:0] CMD_BASE = 32'h0012_3456;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] start_i = 2'b00;
  logic [2*AW-1:0] head_i = '0;
  logic busy_o, done_o, mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [31:0] mem_wdata_o, mem_rdata_i;
  logic mem_gnt_i, mem_rvalid_i;
  logic [7:0] pkt_data_o;
  logic pkt_valid_o, pkt_last_o, pkt_ready_i;
  logic [3:0] cause_set_o;

  always #10 clk = ~clk;

  txring_walker i_txring_walker (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .head_i(head_i),
    .busy_o(busy_o), .done_o(done_o), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_gnt_i(mem_gnt_i), .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i(mem_rdata_i), .pkt_data_o(pkt_data_o),
    .pkt_valid_o(pkt_valid_o), .pkt_last_o(pkt_last_o),
    .pkt_ready_i(pkt_ready_i), .cause_set_o(cause_set_o)
  );

  // memory model, host poke port and output monitor
  logic [31:0] mem [0:1023];
  logic [15:0] lfsr;
  logic bp = 1'b0;
  logic h_we = 1'b0;
  logic [11:0] h_addr = '0;
  logic [31:0] h_data = '0;
  logic [7:0] rxb [0:4095];
  int pend [0:63];
  logic [3:0] clog [0:63];
  int rx_n, pkt_n, cause_n, done_n;

  function automatic logic [7:0] pat(input int b);
    return 8'(b * 7 + 3);
  endfunction

  assign mem_gnt_i   = bp ? (lfsr[1] | lfsr[5]) : 1'b1;
  assign pkt_ready_i = bp ? (lfsr[3] | lfsr[7]) : 1'b1;

  always @(posedge clk) begin
    if (!rst_n) begin
      lfsr <= 16'hACE1;
      mem_rvalid_i <= 1'b0;
      mem_rdata_i <= '0;
      rx_n <= 0; pkt_n <= 0; cause_n <= 0; done_n <= 0;
      for (int w = 0; w < 1024; w++)
        mem[w] <= {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
    end else begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_rvalid_i <= 1'b0;
      if (h_we) mem[h_addr[11:2]] <= h_data;
      if (mem_req_o && mem_gnt_i) begin
        if (mem_we_o) mem[mem_addr_o[11:2]] <= mem_wdata_o;
        else begin
          mem_rvalid_i <= 1'b1;
          mem_rdata_i  <= mem[mem_addr_o[11:2]];
        end
      end
      if (pkt_valid_o && pkt_ready_i) begin
        rxb[rx_n[11:0]] <= pkt_data_o;
        rx_n <= rx_n + 1;
        if (pkt_last_o) begin
          pend[pkt_n[5:0]] <= rx_n + 1;
          pkt_n <= pkt_n + 1;
        end
      end
      if (cause_set_o != 4'b0) begin
        clog[cause_n[5:0]] <= cause_set_o;
        cause_n <= cause_n + 1;
      end
      if (done_o) done_n <= done_n + 1;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [31:0] d);
    @(negedge clk);
    h_we = 1'b1; h_addr = 12'(a); h_data = d;
    @(negedge clk);
    h_we = 1'b0;
  endtask

  task automatic set_desc(input int a, input bit own, input int cnt,
                          input int bufa, input int nxt);
    poke(a,      CMD_BASE | (own ? 32'h8000_0000 : 32'h0));
    poke(a + 4,  {16'(cnt), 16'hBEEF});
    poke(a + 8,  32'(bufa));
    poke(a + 12, 32'(nxt));
  endtask

  task automatic start_q(input logic [1:0] m, input int h0, input int h1);
    @(negedge clk);
    start_i = m; head_i = {32'(h1), 32'(h0)};
    @(negedge clk);
    start_i = 2'b00;
  endtask

  task automatic wait_done(input int base, input string tag);
    int t = 0;
    while (done_n == base && t < 20000) begin
      @(negedge clk);
      t++;
    end
    check(done_n == base + 1, {tag, " done pulse"}, 32'(done_n), 32'(base + 1));
  endtask

  // frame k must hold len bytes starting at buffer byte address a
  task automatic check_pkt(input int k, input int sidx, input int a,
                           input int len, input string tag);
    bit ok = (pend[k] == sidx + len);
    int bad = -1;
    for (int i = 0; i < len; i++)
      if (ok && bad < 0 && rxb[(sidx + i) % 4096] != pat(a + i)) bad = i;
    if (bad >= 0)
      check(1'b0, tag, 32'(rxb[(sidx + bad) % 4096]), 32'(pat(a + bad)));
    else
      check(ok, {tag, " frame length"}, 32'(pend[k] - sidx), 32'(len));
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(!busy_o && !done_o, "R1 busy/done idle", {30'b0, busy_o, done_o}, 0);
    check(!mem_req_o, "R1 no request", 32'(mem_req_o), 0);
    check(!pkt_valid_o, "R1 no packet", 32'(pkt_valid_o), 0);
    check(cause_set_o == 4'b0, "R1 cause clear", 32'(cause_set_o), 0);
  endtask

  task automatic t_single;
    int rb, pb, cb, db;
    bit seen_busy = 1'b0;
    set_desc(16'h010, 1'b1, 5, 16'h104, 16'h010);
    rb = rx_n; pb = pkt_n; cb = cause_n; db = done_n;
    start_q(2'b01, 16'h010, 0);
    seen_busy = busy_o;
    wait_done(db, "R3 single");
    check(seen_busy, "R3 busy during walk", 32'(seen_busy), 1);
    check(pkt_n == pb + 1, "R5 one frame", 32'(pkt_n - pb), 1);
    check_pkt(pb, rb, 16'h104, 5, "R5 aligned frame");
    check(mem[4] == CMD_BASE, "R7 write-back own cleared", mem[4], CMD_BASE);
    check(mem[5] == {16'd5, 16'hBEEF} && mem[6] == 32'h104 && mem[7] == 32'h10,
          "R2 other words untouched", mem[5], {16'd5, 16'hBEEF});
    check(cause_n == cb + 1 && clog[cb] == 4'b1000, "R7 queue 0 cause bit 3",
          32'(clog[cb]), 32'h8);
  endtask

  task automatic t_ring;
    int rb, pb, cb, db;
    bp = 1'b1;
    set_desc(16'h040, 1'b1, 6, 16'h203, 16'h060);
    set_desc(16'h060, 1'b0, 4, 16'h300, 16'h080);
    set_desc(16'h080, 1'b1, 9, 16'h311, 16'h040);
    rb = rx_n; pb = pkt_n; cb = cause_n; db = done_n;
    start_q(2'b10, 0, 16'h040);
    wait_done(db, "R3 ring");
    bp = 1'b0;
    check(pkt_n == pb + 2, "R4 skipped descriptor sends nothing", 32'(pkt_n - pb), 2);
    check_pkt(pb, rb, 16'h203, 6, "R5 unaligned frame under backpressure R10");
    check_pkt(pb + 1, pend[pb], 16'h311, 9, "R5 second frame");
    check(mem[16'h060 >> 2] == CMD_BASE, "R4 unowned word unchanged",
          mem[16'h060 >> 2], CMD_BASE);
    check(mem[16'h040 >> 2] == CMD_BASE && mem[16'h080 >> 2] == CMD_BASE,
          "R7 owned released", mem[16'h080 >> 2], CMD_BASE);
    check(cause_n == cb + 2 && clog[cb] == 4'b0100 && clog[cb + 1] == 4'b0100,
          "R7 queue 1 cause bit 2", 32'(cause_n - cb), 2);
  endtask

  task automatic t_size;
    int rb, pb, cb, db;
    set_desc(16'h0A0, 1'b1, 2048, 16'h800, 16'h0B0);
    set_desc(16'h0B0, 1'b1, 0,    16'h800, 16'h0C0);
    set_desc(16'h0C0, 1'b1, 2047, 16'h800, 16'h0A0);
    rb = rx_n; pb = pkt_n; cb = cause_n; db = done_n;
    start_q(2'b01, 16'h0A0, 0);
    wait_done(db, "R6 sizes");
    check(pkt_n == pb + 1, "R6 oversize and empty send nothing", 32'(pkt_n - pb), 1);
    check_pkt(pb, rb, 16'h800, 2047, "R5 largest legal frame");
    check(mem[16'h0A0 >> 2] == CMD_BASE && mem[16'h0B0 >> 2] == CMD_BASE,
          "R6 dropped descriptors released", mem[16'h0A0 >> 2], CMD_BASE);
    check(cause_n == cb + 3, "R7 cause per owned descriptor", 32'(cause_n - cb), 3);
  endtask

  task automatic t_both;
    int rb, pb, cb, db;
    set_desc(16'h0D0, 1'b1, 3, 16'h120, 16'h0D0);
    set_desc(16'h0E0, 1'b1, 4, 16'h130, 16'h0E0);
    rb = rx_n; pb = pkt_n; cb = cause_n; db = done_n;
    start_q(2'b11, 16'h0E0, 16'h0D0);
    wait_done(db, "R8 both");
    repeat (5) @(negedge clk);
    check(done_n == db + 1, "R8 single done pulse", 32'(done_n - db), 1);
    check(cause_n == cb + 2 && clog[cb] == 4'b0100 && clog[cb + 1] == 4'b1000,
          "R8 queue 1 cause first", {clog[cb], clog[cb + 1]}, 32'h48);
    check_pkt(pb, rb, 16'h120, 3, "R8 queue 1 frame first");
    check_pkt(pb + 1, pend[pb], 16'h130, 4, "R8 queue 0 frame second");
  endtask

  task automatic t_busy;
    int pb, cb, db;
    set_desc(16'h0D0, 1'b1, 3, 16'h120, 16'h0D0);
    set_desc(16'h0E0, 1'b1, 4, 16'h130, 16'h0E0);
    pb = pkt_n; cb = cause_n; db = done_n;
    start_q(2'b10, 16'h0E0, 16'h0D0);
    @(negedge clk);
    check(busy_o, "R9 busy during walk", 32'(busy_o), 1);
    start_q(2'b01, 16'h0E0, 16'h0D0);
    wait_done(db, "R9 busy");
    repeat (30) @(negedge clk);
    check(!busy_o && done_n == db + 1, "R9 engine returns idle", 32'(busy_o), 0);
    check(mem[16'h0E0 >> 2] == (CMD_BASE | 32'h8000_0000), "R9 ignored queue still owned",
          mem[16'h0E0 >> 2], CMD_BASE | 32'h8000_0000);
    check(pkt_n == pb + 1 && cause_n == cb + 1 && clog[cb] == 4'b0100,
          "R9 only queue 1 served", 32'(pkt_n - pb), 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_single;
    t_ring;
    t_size;
    t_both;
    t_busy;
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule